// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block sends 16-bit conversion codes and a 2-bit operating-mode field to a serial voltage-output DAC. It uses three wires: a serial clock, an active-low frame select and a data line. The host offers a code, a mode and a reuse flag on a valid/ready handshake. The block builds a 24-bit frame with six zero pad bits on top, the mode next, and the code underneath. It shifts the frame out most significant bit first as three back-to-back bytes. The frame select stays low for the whole frame and rises only after the last falling clock edge.

The block keeps the last code it sent. A request can set the reuse flag to change only the mode, and the stored code is sent again unchanged. After each frame the block reports the mode now in force and whether the converter is powered down. When a frame takes the converter from a powered-down mode back to normal operation, the block holds its output-valid flag and its ready low for a fixed number of system clocks. This covers the amplifier's start-up time.

Top module: `dacw_ctrl`

## Requirements
- R1: Each frame is exactly 24 bits. Bits 23 to 18 are zero, bits 17 and 16 carry the mode field, and bits 15 to 0 carry the code.
- R2: Bits go out most significant first. The data line changes only while the serial clock rises, and it holds steady across every falling edge, where the converter samples it.
- R3: The frame select goes low at acceptance, before the first rising clock edge. It stays low through all 24 falling edges and rises one clock half-period after the 24th falling edge. The serial clock is low whenever the frame select is high.
- R4: Each high and low phase of the serial clock lasts CLK_DIV system clocks.
- R5: Ready is high only when the block is idle, and a request is taken on a cycle with valid and ready both high. Between frames the frame select stays high for at least 2*CLK_DIV system clocks.
- R6: When the reuse flag is 1, bits 15 to 0 of the frame equal the code of the previous frame, and the offered code is ignored.
- R7: Mode encoding: 00 is normal operation, 01 is a 1 kOhm load to ground, 10 is a 100 kOhm load to ground, and 11 is a high-impedance output. The mode output and the power-down flag (set for any mode other than 00) take the new mode's value in the cycle the frame select rises.
- R8: Output-valid is low while the power-down flag is set.
- R9: After a frame that leaves power-down, output-valid and ready both stay low for at least WAKE_CYCLES system clocks after the frame select rises. Both then go high.
- R10: A frame that does not leave power-down causes no wake-up hold, and ready returns about 2*CLK_DIV clocks after the frame select rises.
- R11: Reset drives the frame select high and the serial clock and data line low. It sets the mode to 00 and clears the power-down flag. Output-valid and ready are high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a write |
| req_ready | output | 1 | Block can accept a write |
| req_code | input | 16 | Conversion code |
| req_mode | input | 2 | Operating-mode field |
| req_keep | input | 1 | Reuse the last code sent |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sync_n | output | 1 | Active-low frame select |
| dac_din | output | 1 | Serial data |
| cur_mode | output | 2 | Mode of the last completed frame |
| pd_flag | output | 1 | Converter is powered down |
| out_valid | output | 1 | Analog output has settled |

## Verification
A wrong bit count or a wrong shift position shows at the first frame. The 24 bits captured on the falling edges differ from the expected frame, and the comparison is made the moment the frame select rises. If the stored code or the power-down state were lost, the next reuse frame would carry the wrong low 16 bits, or the next return to normal mode would skip the hold. Either shows within one frame plus WAKE_CYCLES clocks. A divider or gap-counter fault changes the measured clock half-period or the frame-select high time on the very next frame.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  typedef enum logic [1:0] {
    MODE_RUN    = 2'b00,
    MODE_PD_1K  = 2'b01,
    MODE_PD_100K= 2'b10,
    MODE_PD_HIZ = 2'b11
  } dac_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SHIFT, ST_TAIL, ST_GAP, ST_WAKE
  } wr_state_e;
endpackage

// File: rtl/dacw_tick_gen.sv
module dacw_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == TOP);
endmodule

// File: rtl/dacw_shifter.sv
module dacw_shifter #(
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  tick,
  input  logic                  active,
  output logic                  sclk,
  output logic                  din,
  output logic                  last_fall
);
  localparam int BW = $clog2(FRAME_BITS + 1);
  localparam logic [BW-1:0] LAST = BW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [BW-1:0]         bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      bcnt  <= '0;
      sclk  <= 1'b0;
      din   <= 1'b0;
    end else if (load) begin
      shreg <= frame;
      bcnt  <= '0;
      sclk  <= 1'b0;
    end else if (active && tick) begin
      if (!sclk) begin
        sclk  <= 1'b1;
        din   <= shreg[FRAME_BITS-1];
        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
      end else begin
        sclk <= 1'b0;
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  assign last_fall = active && tick && sclk && (bcnt == LAST);
endmodule

// File: rtl/dacw_wake_timer.sv
module dacw_wake_timer #(
  parameter int CYCLES = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] TOP = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == TOP) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dacw_ctrl.sv
module dacw_ctrl #(
  parameter int CODE_W      = 16,
  parameter int MODE_W      = 2,
  parameter int FRAME_BITS  = 24,
  parameter int CLK_DIV     = 2,
  parameter int WAKE_CYCLES = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_keep,
  output logic              dac_sclk,
  output logic              dac_sync_n,
  output logic              dac_din,
  output logic [MODE_W-1:0] cur_mode,
  output logic              pd_flag,
  output logic              out_valid
);
  import dacw_pkg::*;

  localparam int PAD_W = FRAME_BITS - MODE_W - CODE_W;

  wr_state_e         state;
  logic [CODE_W-1:0] last_code;
  logic [MODE_W-1:0] pend_mode;
  logic              gap_cnt;
  logic              tick, last_fall, wake_start, wake_busy, accept, run;
  logic [CODE_W-1:0] sel_code;
  logic [FRAME_BITS-1:0] frame;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign sel_code  = req_keep ? last_code : req_code;
  assign frame     = {{PAD_W{1'b0}}, req_mode, sel_code};
  assign run       = (state == ST_SHIFT) || (state == ST_TAIL) || (state == ST_GAP);
  assign wake_start = (state == ST_GAP) && tick && gap_cnt &&
                      pd_flag == 1'b0 && out_valid == 1'b0;

  dacw_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  dacw_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .frame(frame), .tick(tick),
    .active(state == ST_SHIFT), .sclk(dac_sclk), .din(dac_din),
    .last_fall(last_fall)
  );

  dacw_wake_timer #(.CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst(rst), .start(wake_start), .busy(wake_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      dac_sync_n <= 1'b1;
      last_code  <= '0;
      pend_mode  <= '0;
      gap_cnt    <= 1'b0;
      cur_mode   <= MODE_W'(MODE_RUN);
      pd_flag    <= 1'b0;
      out_valid  <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          dac_sync_n <= 1'b0;
          last_code  <= sel_code;
          pend_mode  <= req_mode;
          state      <= ST_SHIFT;
        end
        ST_SHIFT: if (last_fall) state <= ST_TAIL;
        ST_TAIL: if (tick) begin
          dac_sync_n <= 1'b1;
          cur_mode   <= pend_mode;
          pd_flag    <= (pend_mode != MODE_W'(MODE_RUN));
          if (pend_mode != MODE_W'(MODE_RUN)) out_valid <= 1'b0;
          gap_cnt    <= 1'b0;
          state      <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          gap_cnt <= 1'b1;
          if (gap_cnt) state <= out_valid || pd_flag ? ST_IDLE : ST_WAKE;
        end
        ST_WAKE: if (!wake_busy && !wake_start) begin
          out_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dacw_ctrl_chk.sv
module dacw_ctrl_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              dac_sclk,
  input logic              dac_sync_n,
  input logic              dac_din,
  input logic [MODE_W-1:0] cur_mode,
  input logic              pd_flag,
  input logic              out_valid
);
  p_sclk_low_idle_r3: assert property (@(posedge clk) disable iff (rst)
    dac_sync_n |-> !dac_sclk);

  p_din_held_at_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_sclk) |-> $stable(dac_din));

  p_ready_outside_frame_r5: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> dac_sync_n);

  p_no_ready_at_frame_end_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_sync_n) |-> !req_ready);

  p_pd_blocks_valid_r8: assert property (@(posedge clk) disable iff (rst)
    pd_flag |-> !out_valid);

  p_mode_steady_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
    (!dac_sync_n && $past(!dac_sync_n)) |-> $stable(cur_mode));

  p_wait_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !pd_flag) |-> !req_ready);
endmodule

bind dacw_ctrl dacw_ctrl_chk #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .dac_sclk(dac_sclk),
  .dac_sync_n(dac_sync_n), .dac_din(dac_din), .cur_mode(cur_mode),
  .pd_flag(pd_flag), .out_valid(out_valid)
);

// File: tb/tb_dacw_ctrl.sv
`timescale 1ns/1ps
module tb_dacw_ctrl;
  localparam int DIV  = 2;
  localparam int WAKE = 40;
  localparam int TCK  = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_keep = 1'b0;
  logic [15:0] req_code = '0;
  logic [1:0]  req_mode = '0;
  logic req_ready, dac_sclk, dac_sync_n, dac_din, pd_flag, out_valid;
  logic [1:0] cur_mode;

  int n_chk = 0, n_fail = 0;
  logic [23:0] cap;
  int nbits;
  realtime t_rise, hp, t_up, gap;
  bit have_up = 0;

  always #(TCK/2) clk = ~clk;

  dacw_ctrl #(.CLK_DIV(DIV), .WAKE_CYCLES(WAKE)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .req_mode(req_mode), .req_keep(req_keep),
    .dac_sclk(dac_sclk), .dac_sync_n(dac_sync_n), .dac_din(dac_din),
    .cur_mode(cur_mode), .pd_flag(pd_flag), .out_valid(out_valid)
  );

  always @(negedge dac_sync_n) begin
    cap = '0; nbits = 0;
    if (have_up) gap = $realtime - t_up;
  end
  always @(posedge dac_sync_n) begin t_up = $realtime; have_up = 1; end
  always @(posedge dac_sclk) t_rise = $realtime;
  always @(negedge dac_sclk) if (!dac_sync_n) begin
    hp = $realtime - t_rise;
    cap = {cap[22:0], dac_din};
    nbits++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] c, input logic [1:0] m, input bit keep);
    while (!req_ready) @(negedge clk);
    req_code = c; req_mode = m; req_keep = keep; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge dac_sync_n);
    #1;
  endtask

  task automatic t_reset();
    chk(dac_sync_n == 1, "R11 sync", dac_sync_n, 1);
    chk(dac_sclk == 0 && dac_din == 0, "R11 sclk/din", {dac_sclk, dac_din}, 0);
    chk(cur_mode == 0 && pd_flag == 0, "R11 mode/pd", {cur_mode, pd_flag}, 0);
    chk(out_valid == 1 && req_ready == 1, "R11 valid/ready", {out_valid, req_ready}, 3);
  endtask

  task automatic frame_ok(input logic [15:0] c, input logic [1:0] m, input string tag);
    logic [23:0] exp;
    exp = {6'b0, m, c};
    chk(nbits == 24, {tag, " R3 bit count"}, nbits, 24);
    chk(cap == exp, {tag, " R1 R2 frame"}, cap, exp);
    chk(cur_mode == m, {tag, " R7 mode"}, cur_mode, m);
    chk(pd_flag == (m != 0), {tag, " R7 pd"}, pd_flag, m != 0);
  endtask

  task automatic t_normal();
    int cyc;
    logic [15:0] pats [3] = '{16'hA5C3, 16'h0001, 16'hFFFF};
    foreach (pats[i]) begin
      send(pats[i], 2'b00, 0);
      frame_ok(pats[i], 2'b00, "normal");
      chk(hp == DIV * TCK, "R4 half period", int'(hp), DIV * TCK);
      cyc = 0;
      @(negedge clk);
      while (!req_ready && cyc < 1000) begin cyc++; @(negedge clk); end
      chk(cyc <= 2 * DIV + 3, "R10 no hold", cyc, 2 * DIV + 3);
      chk(out_valid == 1, "R8 valid in run mode", out_valid, 1);
    end
  endtask

  task automatic t_back_to_back();
    send(16'h1234, 2'b00, 0);
    send(16'h4321, 2'b00, 0);
    frame_ok(16'h4321, 2'b00, "b2b");
    chk(gap >= 2 * DIV * TCK, "R5 sync high gap", int'(gap), 2 * DIV * TCK);
  endtask

  task automatic t_powerdown();
    send(16'hBEEF, 2'b00, 0);
    send(16'h0000, 2'b01, 1);
    frame_ok(16'hBEEF, 2'b01, "pd1k R6");
    chk(out_valid == 0, "R8 valid low 1k", out_valid, 0);
    send(16'h5555, 2'b10, 1);
    frame_ok(16'hBEEF, 2'b10, "pd100k R6");
    send(16'h7777, 2'b11, 0);
    frame_ok(16'h7777, 2'b11, "pdhiz");
    chk(out_valid == 0, "R8 valid low hiz", out_valid, 0);
  endtask

  task automatic t_wake();
    int cyc, rdy_early;
    send(16'h0F0F, 2'b01, 0);
    send(16'h1111, 2'b00, 1);
    frame_ok(16'h0F0F, 2'b00, "wake R6");
    cyc = 0; rdy_early = 0;
    @(negedge clk);
    while (!out_valid && cyc < 1000) begin
      if (req_ready) rdy_early++;
      cyc++; @(negedge clk);
    end
    chk(cyc >= WAKE, "R9 hold length min", cyc, WAKE);
    chk(cyc <= WAKE + 2 * DIV + 4, "R9 hold length max", cyc, WAKE + 2 * DIV + 4);
    chk(rdy_early == 0, "R9 ready held low", rdy_early, 0);
    chk(req_ready == 1, "R9 ready after hold", req_ready, 1);
  endtask

  initial begin
    #(200000 * TCK);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_back_to_back();
    t_powerdown();
    t_wake();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule